// File: doc/BRIEF.md
# Reduced Test Register Bank for a Boundary-Scan Port

This block holds the instruction register, the instruction decoder and the data-register path that sit behind a standard 16-state test access port state machine. It serves a memory device whose test feature set is cut down. The boundary scan chain can only capture. It has no preload stage and it never drives pins. The decoded instruction also raises a request that floats the device's functional outputs.

The block receives the test clock, serial data and an active-low test reset. It also receives one-hot state strobes from the port state machine. A small companion state machine module is included to produce those strobes from TMS. Every register captures and shifts on the rising clock edge. The serial output is retimed on the falling edge and is enabled only while a shift state is active.

Top module: `tap_testreg_bank`

## Requirements
- R1: The 3-bit instruction decodes as follows: 000 selects the boundary chain with outputs floated, 001 selects the identification register, 010 selects the boundary chain with outputs floated, 100 selects the boundary chain with outputs driven, and 111 selects the 1-bit bypass register. The unused codes 011, 101 and 110 act as 111.
- R2: A synchronous reset (trst_n low at a rising edge) loads code 001 as the active instruction. A rising edge while the test-logic-reset strobe is high does the same.
- R3: A rising edge in the capture-IR state loads the instruction shift stage with 3'b001, so the first bits read out, LSB first, are 1, 0, 0.
- R4: The active instruction changes only on a rising edge in update-IR (or on reset or test-logic-reset). While a new code is being shifted in, the high-Z request keeps its old value.
- R5: out_hiz is 1 exactly when the active instruction is 000 or 010. It is 0 for every other code, including 100.
- R6: Under code 001, capture-DR loads the 32-bit parameter ID_VALUE, whose bit 0 is 1. Shift-DR then shifts it out LSB first, with TDI entering bit 31.
- R7: Under 000, 010 or 100, capture-DR loads the 71-bit pin_sample bus into the boundary chain. Shift-DR then moves it out LSB first, with TDI entering bit 70, so TDI reappears after 71 shifts. A change on pin_sample after the capture has no effect on the shifted data.
- R8: Under a bypass code, capture-DR clears the bypass bit. Shift-DR gives a 0 first and then the TDI stream delayed by one bit.
- R9: tdo and tdo_oe change on the falling edge of tck. tdo_oe is 1 only while shift-IR or shift-DR is active, and 0 after reset.
- R10: In shift-IR, TDI enters bit 2 of the instruction shift stage and bit 0 drives tdo, giving a 3-bit delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test reset, sampled on tck |
| tdi | input | 1 | Serial test data in |
| st_tlr | input | 1 | Port state is test-logic-reset |
| st_cap_ir | input | 1 | Port state is capture-IR |
| st_shf_ir | input | 1 | Port state is shift-IR |
| st_upd_ir | input | 1 | Port state is update-IR |
| st_cap_dr | input | 1 | Port state is capture-DR |
| st_shf_dr | input | 1 | Port state is shift-DR |
| pin_sample | input | 71 | Parallel sample of the device pins |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_oe | output | 1 | Enable for tdo |
| out_hiz | output | 1 | Request to float the functional outputs |

## Verification
The bench walks all eight instruction codes, in order and in random order. A decoder that dropped the reserved-code fallback would shift out a boundary chain or the ID value where one delayed bit is expected. A decoder that floated the outputs under sample-with-drive would show out_hiz high under 100. Other corner cases use fixed sequences. One checks that out_hiz holds its old value while a new code is shifted, which catches an instruction that takes effect before update. Another runs a reset through test-logic-reset from a floating instruction, which catches an ID that is not reloaded. A third changes the pins during a shift, which exposes a boundary chain that keeps tracking its inputs. The bench also checks the 001 capture pattern and the exact one-bit, three-bit and 71-bit delays, so a register that is off by one stage shows up as shifted data.

// File: rtl/tsr_pkg.sv
// Package for the reduced test register bank.
// Holds the instruction codes, the decoded data-register selection and the
// state encoding for the companion port state machine.
package tsr_pkg;

    localparam int IR_W = 3;

    typedef enum logic [IR_W-1:0] {
        INS_EXTEST = 3'b000,
        INS_IDCODE = 3'b001,
        INS_SAMPZ  = 3'b010,
        INS_SAMPLE = 3'b100,
        INS_BYPASS = 3'b111
    } ins_e;

    typedef struct packed {
        logic use_bsr;
        logic use_id;
        logic use_byp;
        logic float_out;
    } dr_sel_t;

    typedef enum logic [3:0] {
        TS_TLR, TS_RTI,
        TS_SELDR, TS_CAPDR, TS_SHDR, TS_EX1DR, TS_PSDR, TS_EX2DR, TS_UPDR,
        TS_SELIR, TS_CAPIR, TS_SHIR, TS_EX1IR, TS_PSIR, TS_EX2IR, TS_UPIR
    } tap_st_e;

endpackage

// File: rtl/tap_ctrl_fsm.sv
// Companion 16-state test access port controller.
// Steps on the rising edge of tck under TMS and gives one-hot strobes for the
// states that the register bank uses. Assumes trst_n is synchronous to tck.
module tap_ctrl_fsm
    import tsr_pkg::*;
(
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    output logic st_tlr,
    output logic st_cap_ir,
    output logic st_shf_ir,
    output logic st_upd_ir,
    output logic st_cap_dr,
    output logic st_shf_dr
);

    tap_st_e st_q, st_d;

    // State register, reset to test-logic-reset.
    always_ff @(posedge tck) begin
        if (!trst_n) st_q <= TS_TLR;
        else         st_q <= st_d;
    end

    // Next-state choice from TMS.
    always_comb begin
        unique case (st_q)
            TS_TLR:   st_d = tms ? TS_TLR   : TS_RTI;
            TS_RTI:   st_d = tms ? TS_SELDR : TS_RTI;
            TS_SELDR: st_d = tms ? TS_SELIR : TS_CAPDR;
            TS_CAPDR: st_d = tms ? TS_EX1DR : TS_SHDR;
            TS_SHDR:  st_d = tms ? TS_EX1DR : TS_SHDR;
            TS_EX1DR: st_d = tms ? TS_UPDR  : TS_PSDR;
            TS_PSDR:  st_d = tms ? TS_EX2DR : TS_PSDR;
            TS_EX2DR: st_d = tms ? TS_UPDR  : TS_SHDR;
            TS_UPDR:  st_d = tms ? TS_SELDR : TS_RTI;
            TS_SELIR: st_d = tms ? TS_TLR   : TS_CAPIR;
            TS_CAPIR: st_d = tms ? TS_EX1IR : TS_SHIR;
            TS_SHIR:  st_d = tms ? TS_EX1IR : TS_SHIR;
            TS_EX1IR: st_d = tms ? TS_UPIR  : TS_PSIR;
            TS_PSIR:  st_d = tms ? TS_EX2IR : TS_PSIR;
            TS_EX2IR: st_d = tms ? TS_UPIR  : TS_SHIR;
            TS_UPIR:  st_d = tms ? TS_SELDR : TS_RTI;
            default:  st_d = TS_TLR;
        endcase
    end

    // Strobe outputs.
    assign st_tlr    = (st_q == TS_TLR);
    assign st_cap_ir = (st_q == TS_CAPIR);
    assign st_shf_ir = (st_q == TS_SHIR);
    assign st_upd_ir = (st_q == TS_UPIR);
    assign st_cap_dr = (st_q == TS_CAPDR);
    assign st_shf_dr = (st_q == TS_SHDR);

endmodule

// File: rtl/tsr_instr_reg.sv
// Instruction shift stage and active instruction latch.
// Captures the fixed 001 pattern, shifts LSB-first toward tdo and moves the
// shifted code to the active latch in update-IR. Assumes one-hot strobes.
module tsr_instr_reg
    import tsr_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            st_tlr,
    input  logic            st_cap_ir,
    input  logic            st_shf_ir,
    input  logic            st_upd_ir,
    output logic            ir_tdo,
    output logic [IR_W-1:0] act_ins
);

    localparam logic [IR_W-1:0] CAPT_PAT  = {{(IR_W-1){1'b0}}, 1'b1};
    localparam logic [IR_W-1:0] RESET_INS = INS_IDCODE;

    logic [IR_W-1:0] sh_q;
    logic [IR_W-1:0] act_q;

    // Shift stage: capture the check pattern or shift toward tdo.
    always_ff @(posedge tck) begin
        if (!trst_n)        sh_q <= RESET_INS;
        else if (st_cap_ir) sh_q <= CAPT_PAT;
        else if (st_shf_ir) sh_q <= {tdi, sh_q[IR_W-1:1]};
    end

    // Active instruction: reset value, or the shifted code on update.
    always_ff @(posedge tck) begin
        if (!trst_n || st_tlr) act_q <= RESET_INS;
        else if (st_upd_ir)    act_q <= sh_q;
    end

    assign ir_tdo  = sh_q[0];
    assign act_ins = act_q;

    assert_tlr_idcode_R2: assert property (@(posedge tck) disable iff (!trst_n)
        st_tlr |=> (act_ins == INS_IDCODE));

    assert_capture_pat_R3: assert property (@(posedge tck) disable iff (!trst_n)
        st_cap_ir |=> (sh_q[1:0] == 2'b01));

    assert_update_only_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (!st_upd_ir && !st_tlr) |=> $stable(act_ins));

endmodule

// File: rtl/tsr_decode.sv
// Instruction decoder: maps the active code to a data-register selection and
// the output float request. Reserved codes fall back to the bypass register.
module tsr_decode
    import tsr_pkg::*;
(
    input  logic [IR_W-1:0] ins,
    output dr_sel_t         sel
);

    // Decode table.
    always_comb begin
        sel = '0;
        unique case (ins)
            INS_EXTEST: begin sel.use_bsr = 1'b1; sel.float_out = 1'b1; end
            INS_IDCODE: sel.use_id = 1'b1;
            INS_SAMPZ:  begin sel.use_bsr = 1'b1; sel.float_out = 1'b1; end
            INS_SAMPLE: sel.use_bsr = 1'b1;
            default:    sel.use_byp = 1'b1;
        endcase
    end

    // Exactly one data register is selected, and floating implies the chain.
    always_comb begin
        assert_one_dr_R1: assert ($countones({sel.use_bsr, sel.use_id, sel.use_byp}) == 1);
        assert_hiz_bsr_R5: assert (!(sel.float_out && !sel.use_bsr));
    end

endmodule

// File: rtl/tsr_data_regs.sv
// Data-register path: bypass bit, identification register and a capture-only
// boundary chain. Only the selected register captures or shifts, and its
// LSB is sent to dr_tdo. Assumes the sel input has exactly one bit set.
module tsr_data_regs
    import tsr_pkg::*;
#(
    parameter int          BSR_LEN  = 71,
    parameter logic [31:0] ID_VALUE = 32'h1A5C_E0B3
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  logic               st_cap_dr,
    input  logic               st_shf_dr,
    input  dr_sel_t            sel,
    input  logic [BSR_LEN-1:0] pin_sample,
    output logic               dr_tdo
);

    localparam int ID_W = 32;

    logic               byp_q;
    logic [ID_W-1:0]    id_q;
    logic [BSR_LEN-1:0] bsr_q;

    logic cap_bsr, shf_bsr;
    assign cap_bsr = st_cap_dr && sel.use_bsr;
    assign shf_bsr = st_shf_dr && sel.use_bsr;

    // Bypass bit: cleared on capture, follows tdi on shift.
    always_ff @(posedge tck) begin
        if (!trst_n)                     byp_q <= 1'b0;
        else if (st_cap_dr && sel.use_byp) byp_q <= 1'b0;
        else if (st_shf_dr && sel.use_byp) byp_q <= tdi;
    end

    // Identification register: load the fixed value, shift LSB first.
    always_ff @(posedge tck) begin
        if (!trst_n)                      id_q <= ID_VALUE;
        else if (st_cap_dr && sel.use_id) id_q <= ID_VALUE;
        else if (st_shf_dr && sel.use_id) id_q <= {tdi, id_q[ID_W-1:1]};
    end

    // Boundary chain, one cell per pin, built from the chain length.
    for (genvar g = 0; g < BSR_LEN; g++) begin : g_bsr
        logic shin;
        if (g == BSR_LEN - 1) begin : g_head
            assign shin = tdi;
        end else begin : g_body
            assign shin = bsr_q[g+1];
        end
        // Cell g: sample its pin on capture, take its neighbour on shift.
        always_ff @(posedge tck) begin
            if (!trst_n)      bsr_q[g] <= 1'b0;
            else if (cap_bsr) bsr_q[g] <= pin_sample[g];
            else if (shf_bsr) bsr_q[g] <= shin;
        end
    end

    // Serial output of the selected register.
    always_comb begin
        if (sel.use_bsr)     dr_tdo = bsr_q[0];
        else if (sel.use_id) dr_tdo = id_q[0];
        else                 dr_tdo = byp_q;
    end

    assert_id_load_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (st_cap_dr && sel.use_id) |=> (id_q == ID_VALUE));

    assert_bsr_capture_R7: assert property (@(posedge tck) disable iff (!trst_n)
        cap_bsr |=> (bsr_q == $past(pin_sample)));

    assert_bypass_clear_R8: assert property (@(posedge tck) disable iff (!trst_n)
        (st_cap_dr && sel.use_byp) |=> (byp_q == 1'b0));

endmodule

// File: rtl/tap_testreg_bank.sv
// Top of the reduced test register bank.
// Joins the instruction stage, the decoder and the data-register path, and
// retimes the serial output and its enable on the falling edge of tck.
// Assumes the state strobes come from a standard port controller on tck.
module tap_testreg_bank
    import tsr_pkg::*;
#(
    parameter int          BSR_LEN  = 71,
    parameter logic [31:0] ID_VALUE = 32'h1A5C_E0B3
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  logic               st_tlr,
    input  logic               st_cap_ir,
    input  logic               st_shf_ir,
    input  logic               st_upd_ir,
    input  logic               st_cap_dr,
    input  logic               st_shf_dr,
    input  logic [BSR_LEN-1:0] pin_sample,
    output logic               tdo,
    output logic               tdo_oe,
    output logic               out_hiz
);

    logic            ir_tdo;
    logic            dr_tdo;
    logic [IR_W-1:0] act_ins;
    dr_sel_t         sel;
    logic            tdo_q, oe_q;

    tsr_instr_reg u_ir (
        .tck       (tck),
        .trst_n    (trst_n),
        .tdi       (tdi),
        .st_tlr    (st_tlr),
        .st_cap_ir (st_cap_ir),
        .st_shf_ir (st_shf_ir),
        .st_upd_ir (st_upd_ir),
        .ir_tdo    (ir_tdo),
        .act_ins   (act_ins)
    );

    tsr_decode u_dec (
        .ins (act_ins),
        .sel (sel)
    );

    tsr_data_regs #(
        .BSR_LEN  (BSR_LEN),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck        (tck),
        .trst_n     (trst_n),
        .tdi        (tdi),
        .st_cap_dr  (st_cap_dr),
        .st_shf_dr  (st_shf_dr),
        .sel        (sel),
        .pin_sample (pin_sample),
        .dr_tdo     (dr_tdo)
    );

    // Falling-edge retiming of the serial output and its enable.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            oe_q  <= st_shf_ir || st_shf_dr;
            tdo_q <= st_shf_ir ? ir_tdo : dr_tdo;
        end
    end

    assign tdo     = tdo_q;
    assign tdo_oe  = oe_q;
    assign out_hiz = sel.float_out;

    assert_oe_in_shift_R9: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (st_shf_ir || st_shf_dr));

endmodule

// File: tb/tap_testreg_bank_tb.sv
// Bench: drives TMS through the companion controller and compares the serial
// stream and the float request with values computed here.
module tap_testreg_bank_tb;

    localparam int          BSR_LEN = 71;
    localparam logic [31:0] ID_VAL  = 32'h1A5C_E0B3;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic [BSR_LEN-1:0] pins = '0;
    logic st_tlr, st_cap_ir, st_shf_ir, st_upd_ir, st_cap_dr, st_shf_dr;
    logic tdo, tdo_oe, out_hiz;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 tck = ~tck;

    tap_ctrl_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms),
        .st_tlr(st_tlr), .st_cap_ir(st_cap_ir), .st_shf_ir(st_shf_ir),
        .st_upd_ir(st_upd_ir), .st_cap_dr(st_cap_dr), .st_shf_dr(st_shf_dr)
    );

    tap_testreg_bank #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VAL)) u_dut (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .st_tlr(st_tlr), .st_cap_ir(st_cap_ir), .st_shf_ir(st_shf_ir),
        .st_upd_ir(st_upd_ir), .st_cap_dr(st_cap_dr), .st_shf_dr(st_shf_dr),
        .pin_sample(pins), .tdo(tdo), .tdo_oe(tdo_oe), .out_hiz(out_hiz)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One tck period: drive after a rising edge, sample after the falling edge.
    task automatic step(input logic m, input logic d, output logic o, output logic e);
        tms = m;
        tdi = d;
        @(negedge tck);
        #1;
        o = tdo;
        e = tdo_oe;
        @(posedge tck);
        #1;
    endtask

    function automatic bit exp_hiz(input logic [2:0] c);
        return (c == 3'b000) || (c == 3'b010);
    endfunction

    // Shift n bits through the instruction stage from run-test/idle and update.
    task automatic shift_ir(input int n, input logic [127:0] din, input bit hiz_during,
                            output logic [127:0] dout);
        logic o, e;
        dout = '0;
        step(1, 0, o, e); step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o, e);
            dout[i] = o;
            chk(e == 1'b1, "R9 oe in shift-IR", e, 1);
            chk(out_hiz == hiz_during, "R4 hiz held during IR shift", out_hiz, hiz_during);
        end
        step(1, 0, o, e);
        step(0, 0, o, e);
    endtask

    task automatic load_ins(input logic [2:0] c);
        logic [127:0] d;
        shift_ir(3, {125'b0, c}, out_hiz, d);
    endtask

    // Capture and shift n bits of the selected data register; pins change
    // after the capture to show the chain holds its sample.
    task automatic shift_dr(input int n, input logic [127:0] din, output logic [127:0] dout);
        logic o, e;
        dout = '0;
        step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
        for (int i = 0; i < n; i++) begin
            pins = {$urandom, $urandom, $urandom};
            step(i == n - 1, din[i], o, e);
            dout[i] = o;
            chk(e == 1'b1, "R9 oe in shift-DR", e, 1);
        end
        step(1, 0, o, e);
        step(0, 0, o, e);
        chk(tdo_oe == 1'b0, "R9 oe off outside shift", tdo_oe, 0);
    endtask

    // Load a code, check the float request and its data register.
    task automatic exercise(input logic [2:0] c);
        logic [127:0] din, dout, exp;
        logic [BSR_LEN-1:0] snap;
        int n;
        load_ins(c);
        chk(out_hiz == exp_hiz(c), "R5 hiz per code", out_hiz, exp_hiz(c));
        din  = {$urandom, $urandom, $urandom, $urandom};
        pins = {$urandom, $urandom, $urandom};
        snap = pins;
        exp  = '0;
        if (c == 3'b000 || c == 3'b010 || c == 3'b100) begin
            n = BSR_LEN + 8;
            exp[BSR_LEN-1:0] = snap;
            exp[BSR_LEN+7:BSR_LEN] = din[7:0];
        end else if (c == 3'b001) begin
            n = 40;
            exp[31:0]  = ID_VAL;
            exp[39:32] = din[7:0];
        end else begin
            n = 9;
            exp[0] = 1'b0;
            exp[8:1] = din[7:0];
        end
        shift_dr(n, din, dout);
        for (int i = n; i < 128; i++) dout[i] = 1'b0;
        chk(dout == exp, (c == 3'b001) ? "R6 ID path" :
                         (n == 9) ? "R1 R8 bypass path" : "R7 boundary path", dout, exp);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic o, e;
        logic [127:0] din, dout;
        int seed;
        seed = $urandom(32'd1234);
        // Reset.
        trst_n = 1'b0;
        step(1, 0, o, e); step(1, 0, o, e); step(1, 0, o, e);
        trst_n = 1'b1;
        step(0, 0, o, e);
        chk(tdo_oe == 1'b0, "R9 oe after reset", tdo_oe, 0);
        chk(out_hiz == 1'b0, "R2 hiz after reset", out_hiz, 0);

        // ID shifts out after reset with no instruction load.
        shift_dr(32, 128'h0, dout);
        chk(dout[31:0] == ID_VAL, "R2 R6 ID after reset", dout[31:0], ID_VAL);

        // Capture pattern.
        shift_ir(3, 128'h1, 1'b0, dout);
        chk(dout[2:0] == 3'b001, "R3 capture pattern", dout[2:0], 3'b001);

        // Instruction path delay: 6 bits, last three give BYPASS.
        din = 128'b111_101;
        shift_ir(6, din, 1'b0, dout);
        chk(dout[2:0] == 3'b001, "R3 capture pattern 6-bit", dout[2:0], 3'b001);
        chk(dout[5:3] == din[2:0], "R10 IR three-bit delay", dout[5:3], din[2:0]);
        exercise(3'b111);

        // Every code in order.
        for (int c = 0; c < 8; c++) exercise(c[2:0]);

        // Random codes.
        for (int r = 0; r < 12; r++) exercise(3'($urandom));

        // Update-only: floating stays until update.
        load_ins(3'b000);
        chk(out_hiz == 1'b1, "R5 hiz under 000", out_hiz, 1);
        shift_ir(3, 128'h1, 1'b1, dout);
        chk(out_hiz == 1'b0, "R4 hiz after update to 001", out_hiz, 0);

        // Test-logic-reset from a floating instruction.
        load_ins(3'b010);
        chk(out_hiz == 1'b1, "R5 hiz under 010", out_hiz, 1);
        for (int k = 0; k < 5; k++) step(1, 0, o, e);
        step(0, 0, o, e);
        chk(out_hiz == 1'b0, "R2 hiz after test-logic-reset", out_hiz, 0);
        shift_dr(32, 128'h0, dout);
        chk(dout[31:0] == ID_VAL, "R2 ID after test-logic-reset", dout[31:0], ID_VAL);
        chk(ID_VAL[0] == 1'b1, "R6 ID bit 0 set", ID_VAL[0], 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule